// File: doc/BRIEF.md
# Core Clock Start-Up Delay and Ratio Divider

This block decides when the core of a small controller may start clocking after a wake event or a change of oscillator. A single-cycle `wake` pulse samples the 3-bit oscillator source code and starts a settling delay. The length of that delay depends on the kind of source. Crystal sources count a fixed number of oscillator cycles and then a number of reference ticks. The on-chip RC source counts only reference ticks. Every other source counts a short run of oscillator cycles. The reference tick is a single-cycle pulse from a fixed-rate timebase, for example one per microsecond.

Once the delay is over, `ready` rises and the block issues clock-enable pulses for the core. The spacing of these pulses comes from an 8-bit ratio register that software may rewrite at any moment. A new ratio takes effect only when the current core period ends, so no period is ever cut short. A peripheral enable fires on every second core pulse. A low-power select bit is kept as well; it can only be held at 1 while the programmed ratio keeps the core clock at or below a frequency limit.

Top module: `cclk_wake_div`

## Requirements
- R1: After reset `ready`, `cclk_en`, `pclk_en` and `lp_sel` are 0, and `ready` stays 0 until a `wake` pulse is sampled.
- R2: For crystal source codes 0, 1 and 2, `ready` rises at the clock edge that samples the XTAL_TICKS-th (default 100) `ref_tick`. Only ticks sampled after the first XTAL_CYC (default 1024) edges following the wake edge are counted.
- R3: For source code 3 (RC), `ready` rises at the edge that samples the RC_TICKS-th (default 300) `ref_tick` after the wake edge, with no cycle-count phase.
- R4: For source codes 4 to 7, `ready` rises exactly SHORT_CYC (default 32) edges after the edge that samples `wake`.
- R5: A `wake` pulse sampled while a delay is running, or while running, drops `ready` at that edge and restarts the full delay for the newly sampled source.
- R6: The active divider value N gives a core ratio R of 1 when N is 0 and 2×N otherwise. While `ready` is high, `cclk_en` pulses once every R cycles, and the first pulse comes R cycles after `ready` rises.
- R7: A value written through `div_we`/`div_wdata` is applied only when the current core period completes. The period in progress keeps the old ratio.
- R8: The divider value 255 gives a period of 510 cycles.
- R9: `pclk_en` is high together with every second `cclk_en` pulse, starting with the second pulse after `ready` rises.
- R10: `lp_sel` is set through `lp_we` with `lp_wdata`=1 only if OSC_KHZ ≤ LP_MAX_KHZ × R; otherwise the write leaves it 0. Writing 0 always clears it. It clears by itself one cycle after a newly applied ratio makes OSC_KHZ > LP_MAX_KHZ × R.
- R11: `cclk_en` and `pclk_en` are 0 whenever `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Single-cycle pulse from a fixed-rate timebase |
| src_sel | input | 3 | Oscillator source code, sampled on wake |
| wake | input | 1 | Start or restart of the settling delay |
| div_we | input | 1 | Divider register write strobe |
| div_wdata | input | DIV_W | Divider value N |
| lp_we | input | 1 | Low-power bit write strobe |
| lp_wdata | input | 1 | Low-power bit write value |
| ready | output | 1 | Settling delay complete |
| cclk_en | output | 1 | Core clock enable pulse |
| pclk_en | output | 1 | Peripheral clock enable pulse |
| lp_sel | output | 1 | Low-power select bit |

## Verification
The effects of a wrong internal state show up at specific points on the ports:
- A phase or counter fault in the delay machine moves the rising edge of `ready`. The bench measures that edge to the exact cycle against the delay it computes from the tick pattern, so an off-by-one error appears at the end of the delay.
- A divider that loads a new value too early shows a wrong gap in the very period where the write lands.
- A stuck peripheral phase shows within two core pulses.
- A faulty low-power guard shows one cycle after the offending write or ratio change.

// File: rtl/ckw_pkg.sv
package ckw_pkg;

   localparam int SRC_W = 3;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_CYC,
      PH_TIME,
      PH_RUN
   } wake_ph_t;

   typedef enum logic [1:0] {
      DLY_XTAL,
      DLY_RC,
      DLY_SHORT
   } dly_kind_t;

   // Codes 0..2 are crystals, 3 is the RC source, the rest settle quickly.
   function automatic dly_kind_t src_kind(input logic [SRC_W-1:0] s);
      if (s <= SRC_W'(2))
         return DLY_XTAL;
      else if (s == SRC_W'(3))
         return DLY_RC;
      else
         return DLY_SHORT;
   endfunction

endpackage

// File: rtl/ckw_wake_timer.sv
module ckw_wake_timer
   import ckw_pkg::*;
#(
   parameter int XTAL_CYC   = 1024,
   parameter int XTAL_TICKS = 100,
   parameter int RC_TICKS   = 300,
   parameter int SHORT_CYC  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wake,
   input  logic [SRC_W-1:0] src,
   input  logic             ref_tick,
   output logic             ready
);

   localparam int CYC_MAX  = (XTAL_CYC > SHORT_CYC) ? XTAL_CYC : SHORT_CYC;
   localparam int TICK_MAX = (XTAL_TICKS > RC_TICKS) ? XTAL_TICKS : RC_TICKS;
   localparam int CYC_W    = $clog2(CYC_MAX);
   localparam int TICK_W   = $clog2(TICK_MAX);

   generate
      if (XTAL_CYC < 2 || SHORT_CYC < 2) begin : g_bad_cyc
         $error("ckw_wake_timer: cycle counts must be at least 2");
      end
      if (XTAL_TICKS < 2 || RC_TICKS < 2) begin : g_bad_tick
         $error("ckw_wake_timer: tick counts must be at least 2");
      end
   endgenerate

   wake_ph_t          ph_q;
   dly_kind_t         kind_q;
   dly_kind_t         kind_new;
   logic [CYC_W-1:0]  cyc_cnt;
   logic [TICK_W-1:0] tick_cnt;
   logic [CYC_W-1:0]  cyc_last;
   logic [TICK_W-1:0] tick_last;

   assign kind_new  = src_kind(src);
   assign cyc_last  = (kind_q == DLY_XTAL) ? CYC_W'(XTAL_CYC - 1) : CYC_W'(SHORT_CYC - 1);
   assign tick_last = (kind_q == DLY_XTAL) ? TICK_W'(XTAL_TICKS - 1) : TICK_W'(RC_TICKS - 1);
   assign ready     = (ph_q == PH_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= PH_IDLE;
         kind_q   <= DLY_SHORT;
         cyc_cnt  <= '0;
         tick_cnt <= '0;
      end else if (wake) begin
         kind_q   <= kind_new;
         cyc_cnt  <= '0;
         tick_cnt <= '0;
         ph_q     <= (kind_new == DLY_RC) ? PH_TIME : PH_CYC;
      end else begin
         case (ph_q)
            PH_CYC: begin
               if (cyc_cnt == cyc_last) begin
                  cyc_cnt <= '0;
                  ph_q    <= (kind_q == DLY_XTAL) ? PH_TIME : PH_RUN;
               end else begin
                  cyc_cnt <= cyc_cnt + CYC_W'(1);
               end
            end
            PH_TIME: begin
               if (ref_tick) begin
                  if (tick_cnt == tick_last)
                     ph_q <= PH_RUN;
                  else
                     tick_cnt <= tick_cnt + TICK_W'(1);
               end
            end
            default: ;
         endcase
      end
   end

   // R5: a sampled wake always takes the block out of the running phase
   a_r5_wake_drops: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !ready);

   // R2: crystal sources reach the running phase only through the tick phase
   a_r2_xtal_order: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ready) && kind_q == DLY_XTAL) |-> $past(ph_q) == PH_TIME);

   // R3: the RC source never spends time in the cycle-count phase
   a_r3_rc_no_cycles: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_CYC) |-> kind_q != DLY_RC);

endmodule

// File: rtl/ckw_ratio_div.sv
module ckw_ratio_div #(
   parameter int DIV_W = 8,
   localparam int RAT_W = DIV_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             div_we,
   input  logic [DIV_W-1:0] div_wdata,
   output logic             cclk_en,
   output logic             pclk_en,
   output logic [RAT_W-1:0] ratio
);

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_w
         $error("ckw_ratio_div: DIV_W must lie in 1..16");
      end
   endgenerate

   logic [DIV_W-1:0] pend_q;
   logic [DIV_W-1:0] act_q;
   logic [RAT_W-1:0] cnt_q;
   logic             phase_q;
   logic             term;

   assign ratio   = (act_q == '0) ? RAT_W'(1) : {act_q, 1'b0};
   assign term    = (cnt_q == ratio - RAT_W'(1));
   assign cclk_en = run & term;
   assign pclk_en = cclk_en & phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= '0;
      else if (div_we)
         pend_q <= div_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= '0;
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (!run) begin
         act_q   <= pend_q;
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (term) begin
         act_q   <= pend_q;
         cnt_q   <= '0;
         phase_q <= ~phase_q;
      end else begin
         cnt_q   <= cnt_q + RAT_W'(1);
      end
   end

   // R7: the ratio in use never changes inside a core period
   a_r7_hold_ratio: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !term) |=> $stable(act_q));

   // R6: with a nonzero value pending, pulses are never back to back
   a_r6_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (cclk_en && pend_q != '0 && !div_we) |=> !cclk_en);

   // R9: the first pulse after a restart is never a peripheral pulse
   a_r9_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !pclk_en);

endmodule

// File: rtl/ckw_lp_guard.sv
module ckw_lp_guard #(
   parameter int RAT_W      = 9,
   parameter int OSC_KHZ    = 14746,
   parameter int LP_MAX_KHZ = 8000,
   parameter bit GUARD      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lp_we,
   input  logic             lp_wdata,
   input  logic [RAT_W-1:0] ratio,
   output logic             lp_sel
);

   generate
      if (OSC_KHZ < 1 || LP_MAX_KHZ < 1) begin : g_bad_f
         $error("ckw_lp_guard: frequencies must be positive");
      end
   endgenerate

   logic lp_q;
   assign lp_sel = lp_q;

   generate
      if (GUARD) begin : g_guarded
         logic ok;
         assign ok = (32'(OSC_KHZ) <= 32'(LP_MAX_KHZ) * 32'(ratio));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lp_q <= 1'b0;
            else if (lp_we)
               lp_q <= lp_wdata & ok;
            else if (!ok)
               lp_q <= 1'b0;
         end

         // R10: a ratio that breaks the limit clears the bit on the next edge
         a_r10_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (lp_q && !ok) |=> !lp_q);
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lp_q <= 1'b0;
            else if (lp_we)
               lp_q <= lp_wdata;
         end
      end
   endgenerate

   // R10: writing 0 always clears the bit
   a_r10_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_we && !lp_wdata) |=> !lp_sel);

endmodule

// File: rtl/cclk_wake_div.sv
module cclk_wake_div
   import ckw_pkg::*;
#(
   parameter int DIV_W      = 8,
   parameter int XTAL_CYC   = 1024,
   parameter int XTAL_TICKS = 100,
   parameter int RC_TICKS   = 300,
   parameter int SHORT_CYC  = 32,
   parameter int OSC_KHZ    = 14746,
   parameter int LP_MAX_KHZ = 8000,
   parameter bit LP_GUARD   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic [2:0]       src_sel,
   input  logic             wake,
   input  logic             div_we,
   input  logic [DIV_W-1:0] div_wdata,
   input  logic             lp_we,
   input  logic             lp_wdata,
   output logic             ready,
   output logic             cclk_en,
   output logic             pclk_en,
   output logic             lp_sel
);

   localparam int RAT_W = DIV_W + 1;

   generate
      if (SRC_W != 3) begin : g_bad_src
         $error("cclk_wake_div: source code width mismatch");
      end
   endgenerate

   logic [RAT_W-1:0] ratio;

   ckw_wake_timer #(
      .XTAL_CYC   (XTAL_CYC),
      .XTAL_TICKS (XTAL_TICKS),
      .RC_TICKS   (RC_TICKS),
      .SHORT_CYC  (SHORT_CYC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .wake     (wake),
      .src      (src_sel),
      .ref_tick (ref_tick),
      .ready    (ready)
   );

   ckw_ratio_div #(
      .DIV_W (DIV_W)
   ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (ready),
      .div_we    (div_we),
      .div_wdata (div_wdata),
      .cclk_en   (cclk_en),
      .pclk_en   (pclk_en),
      .ratio     (ratio)
   );

   ckw_lp_guard #(
      .RAT_W      (RAT_W),
      .OSC_KHZ    (OSC_KHZ),
      .LP_MAX_KHZ (LP_MAX_KHZ),
      .GUARD      (LP_GUARD)
   ) u_lp (
      .clk      (clk),
      .rst_n    (rst_n),
      .lp_we    (lp_we),
      .lp_wdata (lp_wdata),
      .ratio    (ratio),
      .lp_sel   (lp_sel)
   );

   // R11: no enable leaves the block while the settling delay is open
   a_r11_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (!cclk_en && !pclk_en));

endmodule

// File: tb/cclk_wake_div_bench.sv
`timescale 1ns/1ps
module cclk_wake_div_bench;

   localparam int TICKP = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b0;
   logic [2:0] src_sel = '0;
   logic       wake = 1'b0;
   logic       div_we = 1'b0;
   logic [7:0] div_wdata = '0;
   logic       lp_we = 1'b0;
   logic       lp_wdata = 1'b0;
   logic       ready, cclk_en, pclk_en, lp_sel;

   typedef struct {
      int    val;
      string req;
   } exp_t;

   exp_t dly_q[$];
   exp_t gap_q[$];
   exp_t mon_e;

   int cyc = 0;
   int n_cmp = 0;
   int n_bad = 0;
   int wake_edge = 0;
   int last_pulse = 0;
   int pulse_idx = 0;
   int r11_bad = 0;
   logic ready_d = 1'b0;
   bit done = 1'b0;

   cclk_wake_div u_cclk_wake_div (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .src_sel(src_sel),
      .wake(wake), .div_we(div_we), .div_wdata(div_wdata),
      .lp_we(lp_we), .lp_wdata(lp_wdata), .ready(ready),
      .cclk_en(cclk_en), .pclk_en(pclk_en), .lp_sel(lp_sel)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   // tick is sampled at every edge whose number is a multiple of TICKP
   always @(negedge clk) ref_tick <= ((cyc + 1) % TICKP == 0);

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   function automatic int exp_delay(input int w, input logic [2:0] s);
      int start, need;
      if (s >= 3'd4) return 32;
      start = (s == 3'd3) ? w + 1 : w + 1025;
      need  = (s == 3'd3) ? 300 : 100;
      for (int e = start; e < start + 100000; e++) begin
         if (e % TICKP == 0) begin
            need--;
            if (need == 0) return e - w;
         end
      end
      return -1;
   endfunction

   // monitor: pops expected items as the design produces events
   always @(negedge clk) begin
      if (rst_n) begin
         if (!ready && (cclk_en || pclk_en)) r11_bad++;
         if (ready && !ready_d) begin
            last_pulse = cyc - 1;
            pulse_idx  = 0;
            if (dly_q.size() > 0) begin
               mon_e = dly_q.pop_front();
               check({mon_e.req, " delay"}, cyc - wake_edge, mon_e.val);
            end
         end
         if (cclk_en) begin
            pulse_idx++;
            if (gap_q.size() > 0) begin
               mon_e = gap_q.pop_front();
               check({mon_e.req, " gap"}, cyc - last_pulse, mon_e.val);
               check("R9 pclk phase", int'(pclk_en), int'(pulse_idx % 2 == 0));
            end
            last_pulse = cyc;
         end
      end
      ready_d = ready;
   end

   // driver: wake with a source, push expected delay and gaps
   task automatic do_wake(input logic [2:0] s, input string req, input int r, input int n);
      @(negedge clk);
      src_sel   = s;
      wake      = 1'b1;
      wake_edge = cyc + 1;
      dly_q.delete();
      gap_q.delete();
      dly_q.push_back('{val: exp_delay(cyc + 1, s), req: req});
      @(negedge clk);
      wake = 1'b0;
      check("R5 ready drops after wake", int'(ready), 0);
      for (int i = 0; i < n; i++) gap_q.push_back('{val: r, req: "R6"});
   endtask

   task automatic set_div(input logic [7:0] v);
      div_we    = 1'b1;
      div_wdata = v;
      @(negedge clk);
      div_we = 1'b0;
   endtask

   task automatic set_lp(input logic v);
      @(negedge clk);
      lp_we    = 1'b1;
      lp_wdata = v;
      @(negedge clk);
      lp_we = 1'b0;
   endtask

   task automatic wait_ready(input string req, input int lim);
      int k = 0;
      while (!ready && k < lim) begin
         @(negedge clk);
         k++;
      end
      if (!ready) check({req, " ready timeout"}, 0, 1);
   endtask

   task automatic wait_gaps(input int lim);
      int k = 0;
      while (gap_q.size() > 0 && k < lim) begin
         @(negedge clk);
         k++;
      end
      check("R6 gap queue drained", gap_q.size(), 0);
   endtask

   task automatic wait_pulse();
      do @(negedge clk); while (!cclk_en);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 ready in reset", int'(ready), 0);
      check("R1 cclk_en in reset", int'(cclk_en), 0);
      check("R1 pclk_en in reset", int'(pclk_en), 0);
      check("R1 lp_sel in reset", int'(lp_sel), 0);
      rst_n = 1'b1;
      repeat (100) @(negedge clk);
      check("R1 no ready without wake", int'(ready), 0);

      // R4 short source, ratio 1
      do_wake(3'd4, "R4", 1, 4);
      wait_ready("R4", 100);
      wait_gaps(50);

      // R3 RC source, N=2 -> ratio 4
      @(negedge clk);
      set_div(8'd2);
      do_wake(3'd3, "R3", 4, 4);
      wait_ready("R3", 3000);
      wait_gaps(100);

      // R2 crystal source, N=1 -> ratio 2
      @(negedge clk);
      set_div(8'd1);
      do_wake(3'd0, "R2", 2, 4);
      wait_ready("R2", 3000);
      wait_gaps(100);

      // R10 write 1 accepted at ratio 2
      set_lp(1'b1);
      check("R10 lp set at ratio 2", int'(lp_sel), 1);

      // R7 change 2 -> 6 mid period
      wait_pulse();
      @(negedge clk);
      gap_q.push_back('{val: 2, req: "R7"});
      gap_q.push_back('{val: 6, req: "R7"});
      gap_q.push_back('{val: 6, req: "R7"});
      set_div(8'd3);
      wait_gaps(100);
      check("R10 lp kept at ratio 6", int'(lp_sel), 1);

      // R8 change 6 -> 510
      wait_pulse();
      @(negedge clk);
      gap_q.push_back('{val: 6, req: "R7"});
      gap_q.push_back('{val: 510, req: "R8"});
      gap_q.push_back('{val: 510, req: "R8"});
      set_div(8'd255);
      wait_gaps(3000);

      // R7 change 510 -> 1
      wait_pulse();
      @(negedge clk);
      gap_q.push_back('{val: 510, req: "R7"});
      gap_q.push_back('{val: 1, req: "R7"});
      gap_q.push_back('{val: 1, req: "R7"});
      set_div(8'd0);
      wait_gaps(1500);
      check("R10 lp auto clear at ratio 1", int'(lp_sel), 0);
      set_lp(1'b1);
      check("R10 lp write rejected at ratio 1", int'(lp_sel), 0);

      // R5 restart during a crystal delay with a short source
      do_wake(3'd1, "R5", 1, 2);
      repeat (300) @(negedge clk);
      check("R2 no early ready", int'(ready), 0);
      do_wake(3'd5, "R5", 1, 2);
      wait_ready("R5", 100);
      wait_gaps(50);

      // R5/R11 restart while running
      repeat (10) @(negedge clk);
      do_wake(3'd6, "R5", 1, 2);
      wait_ready("R5", 100);
      wait_gaps(50);

      // R10 write 0 at a permitted ratio
      @(negedge clk);
      set_div(8'd2);
      repeat (10) @(negedge clk);
      set_lp(1'b1);
      check("R10 lp set at ratio 4", int'(lp_sel), 1);
      set_lp(1'b0);
      check("R10 lp write 0", int'(lp_sel), 0);

      check("R11 enables while not ready", r11_bad, 0);
      check("R5 delay queue drained", dly_q.size(), 0);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule